// File: doc/BRIEF.md
# Subcode Symbol Serial Output Port

This block takes one 8-bit subcode symbol for each subcode frame. The symbol holds bits P through W, and a flag marks whether the frame is one of the two block sync frames. The block hands the symbol to an external controller one bit at a time. Each new symbol is announced by a frame strobe pulse. When the strobe falls, the symbol is loaded and the P bit appears on the serial data line.

The controller then applies rising edges on its own serial clock. Each rising edge moves the line to the next bit. The serial clock is asynchronous, so it passes through a synchronizer and an edge detector in the system clock domain before it moves the line.

A block-sync output reports the sync flag of the frame that is currently loaded. It is high for the two sync frames, so its falling edge marks the first data frame of a subcode block.

The controller must finish reading within a fixed window after each strobe falls. The window is a count of system clocks set by a parameter. Any serial clock edge that arrives after the window has closed sets a sticky overrun flag.

Top module: `sc_subcode_port`

## Requirements
- R1: A `frame_valid` pulse seen while `frame_strobe` is low raises `frame_strobe` on the next cycle. The strobe then stays high for exactly STROBE_CYC cycles and falls.
- R2: A `frame_valid` pulse that arrives while `frame_strobe` is high is ignored. The symbol delivered after the strobe falls is the one latched when the strobe rose.
- R3: In the cycle after `frame_strobe` falls, `ser_data` shows the P bit, which is `frame_sym[7]`.
- R4: Each rising edge of `ser_clk` moves `ser_data` to the next bit. The order is P, Q, R, S, T, U, V, W, which is `frame_sym[7]` down to `frame_sym[0]`. The line changes within three system clock cycles of the edge.
- R5: While no `ser_clk` edge arrives, `ser_data` keeps its current bit, so an unread symbol keeps showing P.
- R6: After the seventh rising edge the line shows W (`frame_sym[0]`). The eighth edge and any later ones leave it at W until the next strobe falls.
- R7: When `frame_strobe` falls, `blk_sync` takes the `frame_is_sync` value of the loaded frame. It holds that value until the next fall, so it drops when the first non-sync frame is loaded.
- R8: A `ser_clk` rising edge detected WINDOW_CYC or more cycles after the last strobe fall (or after reset) sets `overrun`. Edges detected inside the window leave it clear.
- R9: Once set, `overrun` stays high through later frames and reads until reset.
- R10: While and after reset, `frame_strobe`, `blk_sync`, `ser_data` and `overrun` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_valid | input | 1 | One-cycle pulse: a new subcode symbol is offered |
| frame_sym | input | 8 | Symbol bits, P in bit 7 down to W in bit 0 |
| frame_is_sync | input | 1 | Offered frame is one of the two block sync frames |
| ser_clk | input | 1 | Asynchronous bit clock from the controller |
| frame_strobe | output | 1 | Frame strobe; its falling edge loads the new symbol |
| blk_sync | output | 1 | High while the loaded frame is a sync frame |
| ser_data | output | 1 | Serial symbol bit |
| overrun | output | 1 | Sticky flag: a bit clock arrived after the window closed |

## Verification
The read path is driven with a table of symbols chosen to tell different faults apart:
- all zeros and all ones, which expose a stuck data line;
- alternating patterns, which expose a swapped or skipped bit position;
- a walking single bit at each end, which catches a reversed order or an off-by-one in the final hold.

The same table switches the sync flag between runs of sync and data frames. This shows that `blk_sync` changes only when the strobe falls, not when a frame is offered.

Directed cases cover the following:
- a second offer during the strobe, whose data must not replace the first symbol;
- a long idle with no bit clock, during which P must stay on the line;
- a read late inside the window, against one read past it;
- the overrun flag surviving a clean read and clearing on reset.

// File: rtl/sc_sym_pkg.sv
package sc_sym_pkg;
    localparam int SYM_W = 8;
    typedef logic [SYM_W-1:0] sym_t;
endpackage

// File: rtl/sc_edge_sync.sv
module sc_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);
    localparam int CW = STAGES + 1;

    typedef struct packed {
        logic [CW-1:0] chain;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.chain = {st_q.chain[CW-2:0], async_i};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise_o = st_q.chain[STAGES-1] & ~st_q.chain[STAGES];

    // R4: one detected edge per external rising edge
    assert_single_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);
endmodule

// File: rtl/sc_strobe_gen.sv
module sc_strobe_gen
    import sc_sym_pkg::*;
#(
    parameter int STROBE_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_valid_i,
    input  sym_t frame_sym_i,
    input  logic frame_sync_i,
    output logic strobe_o,
    output logic load_o,
    output sym_t sym_o,
    output logic sync_o
);
    localparam int CW = $clog2(STROBE_CYC + 1);

    typedef struct packed {
        logic          strb;
        logic [CW-1:0] cnt;
        sym_t          sym;
        logic          sync;
    } state_t;

    state_t st_d, st_q;
    logic   fall_now;

    always_comb begin
        st_d     = st_q;
        fall_now = st_q.strb && (st_q.cnt == '0);
        if (!st_q.strb) begin
            if (frame_valid_i) begin
                st_d.strb = 1'b1;
                st_d.cnt  = CW'(STROBE_CYC - 1);
                st_d.sym  = frame_sym_i;
                st_d.sync = frame_sync_i;
            end
        end else if (fall_now) begin
            st_d.strb = 1'b0;
        end else begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign strobe_o = st_q.strb;
    assign load_o   = fall_now;
    assign sym_o    = st_q.sym;
    assign sync_o   = st_q.sync;

    // R1: an offer while idle starts the strobe
    assert_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.strb && frame_valid_i) |=> st_q.strb);
    // R2: latched symbol is not replaced while the strobe is high
    assert_no_retrigger_R2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.strb |=> $stable(st_q.sym));
endmodule

// File: rtl/sc_shift_out.sv
module sc_shift_out
    import sc_sym_pkg::*;
#(
    parameter int WINDOW_CYC = 17000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  sym_t sym_i,
    input  logic sync_i,
    input  logic rise_i,
    output logic ser_data_o,
    output logic blk_sync_o,
    output logic overrun_o
);
    localparam int WW = $clog2(WINDOW_CYC + 1);

    typedef struct packed {
        sym_t          sh;
        logic          blk;
        logic [WW-1:0] win;
        logic          ovf;
    } state_t;

    state_t st_d, st_q;
    logic   win_closed;

    always_comb begin
        st_d       = st_q;
        win_closed = (st_q.win == WW'(WINDOW_CYC));
        if (load_i) begin
            st_d.sh  = sym_i;
            st_d.blk = sync_i;
            st_d.win = '0;
        end else begin
            if (!win_closed) st_d.win = st_q.win + 1'b1;
            if (rise_i) begin
                st_d.sh = {st_q.sh[SYM_W-2:0], st_q.sh[0]};
                if (win_closed) st_d.ovf = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ser_data_o = st_q.sh[SYM_W-1];
    assign blk_sync_o = st_q.blk;
    assign overrun_o  = st_q.ovf;

    // R3: P bit on the line right after the load
    assert_p_on_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (ser_data_o == $past(sym_i[SYM_W-1])));
    // R5: no edge, no movement
    assert_hold_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !rise_i) |=> $stable(st_q.sh));
    // R7: block-sync changes only on a load
    assert_blk_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(blk_sync_o));
    // R9: overrun is sticky
    assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        overrun_o |=> overrun_o);
endmodule

// File: rtl/sc_subcode_port.sv
module sc_subcode_port
    import sc_sym_pkg::*;
#(
    parameter int STROBE_CYC  = 8,
    parameter int WINDOW_CYC  = 17000,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       frame_valid,
    input  logic [7:0] frame_sym,
    input  logic       frame_is_sync,
    input  logic       ser_clk,
    output logic       frame_strobe,
    output logic       blk_sync,
    output logic       ser_data,
    output logic       overrun
);
    logic load;
    logic rise;
    sym_t sym_l;
    logic sync_l;

    sc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (ser_clk),
        .rise_o  (rise)
    );

    sc_strobe_gen #(.STROBE_CYC(STROBE_CYC)) u_strobe (
        .clk           (clk),
        .rst_n         (rst_n),
        .frame_valid_i (frame_valid),
        .frame_sym_i   (frame_sym),
        .frame_sync_i  (frame_is_sync),
        .strobe_o      (frame_strobe),
        .load_o        (load),
        .sym_o         (sym_l),
        .sync_o        (sync_l)
    );

    sc_shift_out #(.WINDOW_CYC(WINDOW_CYC)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load),
        .sym_i      (sym_l),
        .sync_i     (sync_l),
        .rise_i     (rise),
        .ser_data_o (ser_data),
        .blk_sync_o (blk_sync),
        .overrun_o  (overrun)
    );
endmodule

// File: tb/sc_subcode_port_test.sv
module sc_subcode_port_test;
    localparam int STROBE_CYC = 6;
    localparam int WINDOW_CYC = 300;
    localparam int NVEC       = 7;
    // {frame_is_sync, frame_sym}
    localparam logic [8:0] VEC [NVEC] = '{
        9'h1_00, 9'h1_FF, 9'h0_A5, 9'h0_5A, 9'h0_80, 9'h1_01, 9'h0_C3
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_valid = 1'b0;
    logic [7:0] frame_sym = '0;
    logic       frame_is_sync = 1'b0;
    logic       ser_clk = 1'b0;
    logic       frame_strobe, blk_sync, ser_data, overrun;
    int         total = 0;
    int         fails = 0;
    logic       done = 1'b0;

    always #4 clk = ~clk;

    sc_subcode_port #(.STROBE_CYC(STROBE_CYC), .WINDOW_CYC(WINDOW_CYC)) uut (
        .clk(clk), .rst_n(rst_n), .frame_valid(frame_valid), .frame_sym(frame_sym),
        .frame_is_sync(frame_is_sync), .ser_clk(ser_clk), .frame_strobe(frame_strobe),
        .blk_sync(blk_sync), .ser_data(ser_data), .overrun(overrun)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic pulse();
        ser_clk = 1'b1; tick(4);
        ser_clk = 1'b0; tick(4);
    endtask

    // offer a frame and wait for the strobe to fall; checks strobe width
    task automatic send(input logic [7:0] s, input logic y, input logic prev_blk);
        int n;
        @(negedge clk);
        frame_sym = s; frame_is_sync = y; frame_valid = 1'b1;
        @(negedge clk);
        frame_valid = 1'b0;
        chk("R1", frame_strobe, 1'b1);
        chk("R7", blk_sync, prev_blk);
        n = 0;
        while (frame_strobe && n < 100) begin n++; @(negedge clk); end
        chk("R1", n, STROBE_CYC);
    endtask

    task automatic read_all(input logic [7:0] s);
        for (int i = 0; i < 8; i++) begin
            if (i == 0) chk("R3", ser_data, s[7]);
            else        chk("R4", ser_data, s[7-i]);
            pulse();
        end
        chk("R6", ser_data, s[0]);
        pulse();
        chk("R6", ser_data, s[0]);
    endtask

    initial begin
        logic prev;
        tick(3);
        chk("R10", {frame_strobe, blk_sync, ser_data, overrun}, 4'b0000);
        rst_n = 1'b1;
        tick(2);
        chk("R10", {frame_strobe, blk_sync, ser_data, overrun}, 4'b0000);

        prev = 1'b0;
        for (int v = 0; v < NVEC; v++) begin
            send(VEC[v][7:0], VEC[v][8], prev);
            chk("R7", blk_sync, VEC[v][8]);
            read_all(VEC[v][7:0]);
            chk("R8", overrun, 1'b0);
            prev = VEC[v][8];
        end

        // R2: second offer during strobe is ignored
        @(negedge clk);
        frame_sym = 8'h3C; frame_is_sync = 1'b0; frame_valid = 1'b1;
        @(negedge clk);
        frame_sym = 8'hC3; frame_valid = 1'b1;
        @(negedge clk);
        frame_valid = 1'b0;
        tick(STROBE_CYC + 2);
        chk("R2", frame_strobe, 1'b0);
        read_all(8'h3C);

        // R5: idle line keeps P
        send(8'h96, 1'b0, 1'b0);
        tick(200);
        chk("R5", ser_data, 1'b1);
        pulse();
        chk("R4", ser_data, 1'b0);
        tick(100);
        chk("R5", ser_data, 1'b0);

        // R8: late inside window, no overrun
        send(8'h40, 1'b0, 1'b0);
        tick(240);
        pulse();
        chk("R8", overrun, 1'b0);
        chk("R4", ser_data, 1'b1);

        // R8: past window sets overrun
        send(8'h40, 1'b0, 1'b0);
        tick(WINDOW_CYC + 40);
        chk("R8", overrun, 1'b0);
        pulse();
        chk("R8", overrun, 1'b1);

        // R9: sticky through a clean read
        send(8'hE7, 1'b1, 1'b0);
        read_all(8'hE7);
        chk("R9", overrun, 1'b1);

        // R10: reset clears everything
        rst_n = 1'b0;
        tick(2);
        chk("R10", {frame_strobe, blk_sync, ser_data, overrun}, 4'b0000);
        rst_n = 1'b1;
        tick(2);
        chk("R9", overrun, 1'b0);

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end
endmodule